// File: doc/BRIEF.md
# Flux pulse data separator

This block sits after a clock recovery stage in a disc read channel. It receives a stream of single-cycle pulses, one for each flux transition read from the medium. It also receives the recovered bit-cell phase as a counter. Each bit cell is split into a clock window followed by a data window. Every pulse is assigned to the window it lands in. At the end of each cell the block presents one serial clock bit and one serial data bit, together with a one-cycle valid strobe.

Alongside decoding, the block grades where each pulse falls inside its window. A pulse that lands within a few ticks of either boundary of its window raises a sticky margin flag. The bit is still decoded normally; the flag only warns that the timing has drifted close to failure. The flag stays set for reading after the operation finishes. It drops only when the explicit clear input is used.

Top module: `flux_separator`

## Requirements
- R1: While rst_n is low and on the first cycle after reset, bit_valid_o, clk_bit_o, data_bit_o and margin_o are all 0.
- R2: A cell spans phase_i values 0 to 2*WIN-1. Phases 0 to WIN-1 (0..15 by default) form the clock window. Any pulse_i=1 sampled there makes clk_bit_o 1 for that cell; otherwise clk_bit_o is 0.
- R3: Phases WIN to 2*WIN-1 (16..31 by default) form the data window. Any pulse sampled there, including one at phase 2*WIN-1, makes data_bit_o 1; otherwise data_bit_o is 0.
- R4: bit_valid_o is 1 for exactly the one cycle after a clock edge that samples phase_i = 2*WIN-1. On that same cycle clk_bit_o and data_bit_o carry that cell's bits, and both hold their values until the next strobe.
- R5: A pulse whose offset inside its window is below MARGIN, or at least WIN-MARGIN (offsets 0,1,14,15 by default), sets margin_o on the next cycle. Such a pulse still decodes to the same bits as a well-centred one.
- R6: Once set, margin_o stays 1 until a clear. Later pulses at safe offsets and completed cells do not lower it.
- R7: margin_clr_i=1 lowers margin_o on the next cycle. When a near-edge pulse is sampled on the same edge, the set wins and margin_o stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pulse_i | input | 1 | One-cycle flux transition pulse |
| phase_i | input | $clog2(2*WIN) | Recovered bit-cell phase, 0 to 2*WIN-1 |
| margin_clr_i | input | 1 | Clears the sticky margin flag |
| clk_bit_o | output | 1 | Decoded clock bit of the last cell |
| data_bit_o | output | 1 | Decoded data bit of the last cell |
| bit_valid_o | output | 1 | One-cycle strobe at the end of each cell |
| margin_o | output | 1 | Sticky near-edge warning |

## Verification
Each decoded cell becomes visible exactly one cycle after the edge that samples the last phase. The bench therefore checks the bits and the strobe at the falling edge that follows it, and checks that the strobe is low again one cycle later. The margin flag also moves one cycle after the pulse or clear is sampled. The clear is applied on an idle cycle, and the flag is checked at the next falling edge. A sweep places a single pulse on every phase of a cell and derives the expected bits and margin from the phase arithmetic.

// File: rtl/flux_separator.sv
module flux_separator #(
  parameter int WIN    = 16,
  parameter int MARGIN = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          pulse_i,
  input  logic [$clog2(2*WIN)-1:0]      phase_i,
  input  logic                          margin_clr_i,
  output logic                          clk_bit_o,
  output logic                          data_bit_o,
  output logic                          bit_valid_o,
  output logic                          margin_o
);
  localparam int PW = $clog2(2*WIN);
  localparam logic [PW-1:0] WIN_P   = PW'(WIN);
  localparam logic [PW-1:0] LAST_P  = PW'(2*WIN-1);
  localparam logic [PW-1:0] LO_EDGE = PW'(MARGIN);
  localparam logic [PW-1:0] HI_EDGE = PW'(WIN-MARGIN);

  logic          in_data;
  logic [PW-1:0] offset;
  logic          near_edge;
  logic          cell_end;
  logic          clk_seen, data_seen;

  assign in_data   = phase_i >= WIN_P;
  assign offset    = in_data ? phase_i - WIN_P : phase_i;
  assign near_edge = pulse_i && (offset < LO_EDGE || offset >= HI_EDGE);
  assign cell_end  = phase_i == LAST_P;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_seen    <= 1'b0;
      data_seen   <= 1'b0;
      clk_bit_o   <= 1'b0;
      data_bit_o  <= 1'b0;
      bit_valid_o <= 1'b0;
    end else begin
      bit_valid_o <= cell_end;
      if (cell_end) begin
        clk_bit_o  <= clk_seen;
        data_bit_o <= data_seen | pulse_i;
        clk_seen   <= 1'b0;
        data_seen  <= 1'b0;
      end else if (pulse_i) begin
        if (in_data) data_seen <= 1'b1;
        else         clk_seen  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            margin_o <= 1'b0;
    else if (near_edge)    margin_o <= 1'b1;
    else if (margin_clr_i) margin_o <= 1'b0;
  end

  // R4: strobe only follows the last phase of a cell
  a_r4_strobe_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid_o |-> $past(phase_i) == LAST_P);
  // R4: bits hold between strobes
  a_r4_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid_o |-> $stable(clk_bit_o) && $stable(data_bit_o));
  // R3: pulse on the last data tick counts
  a_r3_last_tick: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_i && cell_end |=> data_bit_o && bit_valid_o);
  // R5: near-edge pulse raises the flag
  a_r5_margin_set: assert property (@(posedge clk) disable iff (!rst_n)
    near_edge |=> margin_o);
  // R6: flag is sticky without clear
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    margin_o && !margin_clr_i |=> margin_o);
  // R7: clear without a near-edge pulse drops the flag
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    margin_clr_i && !near_edge |=> !margin_o);
endmodule

// File: tb/flux_separator_tb.sv
module flux_separator_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 16;
  localparam int MARGIN = 2;
  localparam int PW = $clog2(2*WIN);

  logic clk = 0, rst_n = 0, pulse_i = 0, margin_clr_i = 0;
  logic [PW-1:0] phase_i = '0;
  logic clk_bit_o, data_bit_o, bit_valid_o, margin_o;
  int checks = 0, failures = 0;
  logic exp_m = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flux_separator #(.WIN(WIN), .MARGIN(MARGIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .pulse_i(pulse_i), .phase_i(phase_i),
    .margin_clr_i(margin_clr_i), .clk_bit_o(clk_bit_o), .data_bit_o(data_bit_o),
    .bit_valid_o(bit_valid_o), .margin_o(margin_o));

  task automatic chk(input string req, input logic act, input logic expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, expv);
    end
  endtask

  function automatic logic near(input int t);
    int o = t % WIN;
    return o < MARGIN || o >= WIN - MARGIN;
  endfunction

  task automatic run_cell(input logic [2*WIN-1:0] pat, input logic clr0);
    logic ec = 0, ed = 0;
    for (int t = 0; t < 2*WIN; t++) begin
      @(negedge clk);
      if (t == 5) chk("R4 strobe low mid-cell", bit_valid_o, 1'b0);
      phase_i = PW'(t);
      pulse_i = pat[t];
      margin_clr_i = clr0 && t == 0;
      if (pat[t]) begin
        if (t < WIN) ec = 1; else ed = 1;
        if (near(t)) exp_m = 1;
      end else if (clr0 && t == 0) exp_m = 0;
    end
    @(negedge clk);
    pulse_i = 0; margin_clr_i = 0; phase_i = '0;
    chk("R4 strobe", bit_valid_o, 1'b1);
    chk("R2 clock bit", clk_bit_o, ec);
    chk("R3 data bit", data_bit_o, ed);
    chk("R5 R6 margin", margin_o, exp_m);
    @(negedge clk);
    chk("R4 strobe one cycle", bit_valid_o, 1'b0);
    chk("R4 clock bit held", clk_bit_o, ec);
    chk("R4 data bit held", data_bit_o, ed);
  endtask

  task automatic clear_idle();
    margin_clr_i = 1;
    @(negedge clk);
    margin_clr_i = 0;
    exp_m = 0;
    chk("R7 clear", margin_o, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid", bit_valid_o, 1'b0);
    chk("R1 margin", margin_o, 1'b0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 clk bit", clk_bit_o, 1'b0);
    chk("R1 data bit", data_bit_o, 1'b0);
    chk("R1 valid after", bit_valid_o, 1'b0);
    run_cell('0, 1'b0);
    for (int p = 0; p < 2*WIN; p++) begin
      run_cell(32'(1) << p, 1'b0);
      clear_idle();
    end
    for (int c = 0; c < WIN; c++)
      for (int d = WIN; d < 2*WIN; d += 5) begin
        run_cell((32'(1) << c) | (32'(1) << d), 1'b0);
        clear_idle();
      end
    // R6: near pulse then safe-only cells keep flag
    run_cell(32'(1) << 1, 1'b0);
    run_cell(32'(1) << 8, 1'b0);
    run_cell(32'(1) << 24, 1'b0);
    // R7: clear with a near-edge pulse on the same edge: set wins
    run_cell(32'(1) << 0, 1'b1);
    // R7: clear with no pulse at phase 0 lowers the flag
    run_cell(32'(1) << 20, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule